// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit carries out the set-type-and-length operation of a vector extension. A decoded request brings the source and destination register indices, a requested type word (either an 8-bit immediate or a full register value), and the application vector length (AVL) read from the first source register. The unit checks the type word, works out the maximum vector length (VLMAX) from the vector register width, the element width (SEW) and the register grouping factor (LMUL), picks the granted length and updates its type, length and vector-start registers.

The granted length is returned on a write-back port in the same cycle as the request, for the register file to store into the destination register. The register width, the widest supported element, the data path width and the policy for the band between VLMAX and twice VLMAX are parameters. The request port is always ready, so every cycle with `req_valid` high is one executed operation. A separate write port lets a trap or restart path load the vector-start register between operations.

Top module: `vcfg_unit`

## Requirements
- R1: After reset the type register reads vill=1 with ma, ta, SEW code and LMUL code all 0, the length reads 0 and the vector start reads 0.
- R2: `wb_idx` equals `req_rd_idx`, and `wb_en` is high exactly when `req_valid` is high and `req_rd_idx` is nonzero.
- R3: With `req_imm_form`=1 the type word is `req_zimm` zero-extended; otherwise it is `req_rs2_val`. In both forms bit 7 is ma, bit 6 is ta, bits 5:3 are the SEW code (0..3 = 8, 16, 32, 64 bits) and bits 2:0 are the LMUL code (0..3 = 1, 2, 4, 8; 5, 6, 7 = 1/8, 1/4, 1/2).
- R4: A type word is illegal when its top bit is set, any bit from 8 up to the next-to-top bit is set, the LMUL code is 4, the SEW code is 4 or above, or SEW exceeds LMUL times ELEN. An illegal word yields vill=1, ma=ta=0, SEW code 0, LMUL code 0 and length 0.
- R5: VLMAX equals VLEN times LMUL divided by SEW; with a nonzero source index and AVL at most VLMAX the granted length is AVL.
- R6: With a nonzero source index and VLMAX < AVL < 2·VLMAX the granted length is ceil(AVL/2) when `MID_HALF`=1 (default) and VLMAX when `MID_HALF`=0.
- R7: With a nonzero source index and AVL of at least 2·VLMAX the granted length is VLMAX.
- R8: With source index 0 and a nonzero destination index the granted length is VLMAX, whatever `req_rs1_val` holds.
- R9: With both indices 0 and a legal type the previous length is kept if the new SEW/LMUL ratio equals the stored one; if the ratio differs the result is vill=1, fields 0 and length 0.
- R10: `wb_data` carries the new length zero-extended to XLEN in the request cycle, and the length register holds that value after the accepting edge.
- R11: Every accepted request clears the vector start register, even when `vstart_wr_en` is high in the same cycle; with no request, `vstart_wr_en` loads `vstart_wr_data`.
- R12: With `req_valid` low the type and length registers keep their values, whatever the other request inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Always high; requests never stall |
| req_imm_form | input | 1 | 1: type from immediate, 0: type from register |
| req_zimm | input | 8 | Immediate type fields {ma, ta, sew, lmul} |
| req_rs2_val | input | XLEN | Register type word |
| req_rs1_idx | input | 5 | AVL source register index |
| req_rs1_val | input | XLEN | AVL value |
| req_rd_idx | input | 5 | Destination register index |
| vstart_wr_en | input | 1 | Load vector start from outside |
| vstart_wr_data | input | VSTART_W | Value for that load |
| wb_en | output | 1 | Destination write enable |
| wb_idx | output | 5 | Destination index |
| wb_data | output | XLEN | Granted length for write-back |
| vtype_vill | output | 1 | Illegal-type flag |
| vtype_ma | output | 1 | Mask-agnostic flag |
| vtype_ta | output | 1 | Tail-agnostic flag |
| vtype_sew | output | 3 | SEW code |
| vtype_lmul | output | 3 | LMUL code |
| vl_out | output | VL_W | Current vector length |
| vstart_out | output | VSTART_W | Current vector start |

## Verification
The vector start register has two writers that can act on the same edge: the clear done by a configuration request and the load from the external write port. The bench first loads a nonzero start value on its own and reads it back, then raises the load and a request in one cycle and expects the register to read zero afterwards, proving the clear wins. A second overlap, the keep-length mode, in which a stored length and a new type meet in one cycle, is judged by steering the ratio first equal and then different and reading both the length and the vill flag.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

   typedef struct packed {
      logic       vill;
      logic       ma;
      logic       ta;
      logic [2:0] sew;
      logic [2:0] lmul;
   } vtype_t;

   localparam vtype_t VTYPE_BAD = '{vill: 1'b1, ma: 1'b0, ta: 1'b0, sew: 3'd0, lmul: 3'd0};

   // base-2 exponent of the grouping factor; codes 5..7 are fractional
   function automatic int lmul_log2(input logic [2:0] code);
      return code[2] ? int'(code) - 8 : int'(code);
   endfunction

   // base-2 exponent of the element width in bits
   function automatic int sew_log2(input logic [2:0] code);
      return 3 + int'(code);
   endfunction

endpackage

// File: rtl/vcfg_type_check.sv
module vcfg_type_check
   import vcfg_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int VLEN = 128,
   parameter int ELEN = 64,
   parameter int VL_W = 8
) (
   input  logic [XLEN-1:0] raw,
   output vtype_t          vtype,
   output logic [VL_W-1:0] vlmax,
   output logic [4:0]      ratio
);
   localparam int VLEN_P = $clog2(VLEN);
   localparam int ELEN_P = $clog2(ELEN);

   logic bad;
   int   lp;
   int   sp;

   always_comb begin
      lp  = lmul_log2(raw[2:0]);
      sp  = sew_log2(raw[5:3]);
      bad = raw[XLEN-1] | (|raw[XLEN-2:8]) | (raw[2:0] == 3'b100) |
            raw[5] | (sp > lp + ELEN_P);
      if (bad) begin
         vtype = VTYPE_BAD;
         vlmax = '0;
      end else begin
         vtype = vtype_t'({1'b0, raw[7:0]});
         vlmax = VL_W'(1) << (VLEN_P + lp - sp);
      end
      ratio = 5'(sp - lp);
   end

endmodule

// File: rtl/vcfg_vl_select.sv
module vcfg_vl_select #(
   parameter int XLEN     = 32,
   parameter int VL_W     = 8,
   parameter bit MID_HALF = 1'b1
) (
   input  logic [XLEN-1:0] avl,
   input  logic [VL_W-1:0] vlmax,
   output logic [VL_W-1:0] vl
);
   logic [XLEN-1:0] lim;
   logic [XLEN-1:0] lim2;
   logic [VL_W-1:0] mid;

   assign lim  = XLEN'(vlmax);
   assign lim2 = lim << 1;

   generate
      if (MID_HALF) begin : g_mid_half
         assign mid = VL_W'(avl >> 1) + VL_W'(avl[0]);
      end else begin : g_mid_max
         assign mid = vlmax;
      end
   endgenerate

   always_comb begin
      if (avl <= lim)      vl = VL_W'(avl);
      else if (avl < lim2) vl = mid;
      else                 vl = vlmax;
   end

endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
   import vcfg_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int VLEN     = 128,
   parameter int ELEN     = 64,
   parameter bit MID_HALF = 1'b1,
   localparam int VL_W     = $clog2(VLEN) + 1,
   localparam int VSTART_W = $clog2(VLEN)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_imm_form,
   input  logic [7:0]          req_zimm,
   input  logic [XLEN-1:0]     req_rs2_val,
   input  logic [4:0]          req_rs1_idx,
   input  logic [XLEN-1:0]     req_rs1_val,
   input  logic [4:0]          req_rd_idx,
   input  logic                vstart_wr_en,
   input  logic [VSTART_W-1:0] vstart_wr_data,
   output logic                wb_en,
   output logic [4:0]          wb_idx,
   output logic [XLEN-1:0]     wb_data,
   output logic                vtype_vill,
   output logic                vtype_ma,
   output logic                vtype_ta,
   output logic [2:0]          vtype_sew,
   output logic [2:0]          vtype_lmul,
   output logic [VL_W-1:0]     vl_out,
   output logic [VSTART_W-1:0] vstart_out
);
   // elaboration-time parameter checks
   generate
      if ((VLEN & (VLEN - 1)) != 0 || (ELEN & (ELEN - 1)) != 0) begin : g_bad_pow2
         $error("VLEN and ELEN must be powers of two");
      end
      if (ELEN < 8 || ELEN > 64 || VLEN < ELEN) begin : g_bad_elen
         $error("need 8 <= ELEN <= 64 and VLEN >= ELEN");
      end
      if (XLEN < VL_W + 2) begin : g_bad_xlen
         $error("XLEN too narrow for twice VLMAX");
      end
   endgenerate

   vtype_t              vtype_q;
   logic [VL_W-1:0]     vl_q;
   logic [VSTART_W-1:0] vstart_q;

   logic [XLEN-1:0]     type_raw;
   vtype_t              chk_vtype;
   logic [VL_W-1:0]     chk_vlmax;
   logic [4:0]          chk_ratio;
   logic [4:0]          old_ratio;
   logic [VL_W-1:0]     sel_vl;
   vtype_t              nx_vtype;
   logic [VL_W-1:0]     nx_vl;

   assign type_raw  = req_imm_form ? XLEN'(req_zimm) : req_rs2_val;
   assign old_ratio = 5'(sew_log2(vtype_q.sew) - lmul_log2(vtype_q.lmul));

   vcfg_type_check #(
      .XLEN (XLEN),
      .VLEN (VLEN),
      .ELEN (ELEN),
      .VL_W (VL_W)
   ) type_chk_i (
      .raw   (type_raw),
      .vtype (chk_vtype),
      .vlmax (chk_vlmax),
      .ratio (chk_ratio)
   );

   vcfg_vl_select #(
      .XLEN     (XLEN),
      .VL_W     (VL_W),
      .MID_HALF (MID_HALF)
   ) vl_sel_i (
      .avl   (req_rs1_val),
      .vlmax (chk_vlmax),
      .vl    (sel_vl)
   );

   always_comb begin
      nx_vtype = chk_vtype;
      nx_vl    = vl_q;
      if (chk_vtype.vill) begin
         nx_vl = '0;
      end else if (req_rs1_idx != 5'd0) begin
         nx_vl = sel_vl;
      end else if (req_rd_idx != 5'd0) begin
         nx_vl = chk_vlmax;
      end else if (chk_ratio != old_ratio) begin
         nx_vtype = VTYPE_BAD;
         nx_vl    = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vtype_q  <= VTYPE_BAD;
         vl_q     <= '0;
         vstart_q <= '0;
      end else begin
         if (req_valid) begin
            vtype_q  <= nx_vtype;
            vl_q     <= nx_vl;
            vstart_q <= '0;
         end else if (vstart_wr_en) begin
            vstart_q <= vstart_wr_data;
         end
      end
   end

   assign req_ready  = 1'b1;
   assign wb_en      = req_valid & (req_rd_idx != 5'd0);
   assign wb_idx     = req_rd_idx;
   assign wb_data    = XLEN'(nx_vl);
   assign vtype_vill = vtype_q.vill;
   assign vtype_ma   = vtype_q.ma;
   assign vtype_ta   = vtype_q.ta;
   assign vtype_sew  = vtype_q.sew;
   assign vtype_lmul = vtype_q.lmul;
   assign vl_out     = vl_q;
   assign vstart_out = vstart_q;

endmodule

// File: rtl/vcfg_unit_chk.sv
module vcfg_unit_chk #(
   parameter int XLEN     = 32,
   parameter int VLEN     = 128,
   parameter int VL_W     = 8,
   parameter int VSTART_W = 7
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                wb_en,
   input logic [4:0]          wb_idx,
   input logic [XLEN-1:0]     wb_data,
   input logic                vtype_vill,
   input logic                vtype_ma,
   input logic                vtype_ta,
   input logic [2:0]          vtype_sew,
   input logic [2:0]          vtype_lmul,
   input logic [VL_W-1:0]     vl_out,
   input logic [VSTART_W-1:0] vstart_out
);
   // R1
   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (vtype_vill && vl_out == '0 && vstart_out == '0));

   // R2
   a_r2_wb_gate: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (req_valid && wb_idx != 5'd0));

   // R4
   a_r4_vill_clears: assert property (@(posedge clk) disable iff (!rst_n)
      vtype_vill |-> (vl_out == '0 && !vtype_ma && !vtype_ta &&
                      vtype_sew == 3'd0 && vtype_lmul == 3'd0));

   // R5
   a_r5_vl_bound: assert property (@(posedge clk) disable iff (!rst_n)
      !vtype_vill |-> (int'(vl_out) <= VLEN));

   // R10
   a_r10_wb_matches_vl: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (XLEN'(vl_out) == $past(wb_data)));

   // R11
   a_r11_vstart_clear: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (vstart_out == '0));

   // R12
   a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(vl_out) && $stable(vtype_vill) && $stable(vtype_sew) &&
                      $stable(vtype_lmul) && $stable(vtype_ma) && $stable(vtype_ta)));

endmodule

bind vcfg_unit vcfg_unit_chk #(
   .XLEN     (XLEN),
   .VLEN     (VLEN),
   .VL_W     (VL_W),
   .VSTART_W (VSTART_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .wb_en      (wb_en),
   .wb_idx     (wb_idx),
   .wb_data    (wb_data),
   .vtype_vill (vtype_vill),
   .vtype_ma   (vtype_ma),
   .vtype_ta   (vtype_ta),
   .vtype_sew  (vtype_sew),
   .vtype_lmul (vtype_lmul),
   .vl_out     (vl_out),
   .vstart_out (vstart_out)
);

// File: tb/vcfg_unit_tb.sv
module vcfg_unit_tb_top;
   localparam int XLEN = 32;
   localparam int VLEN = 128;
   localparam int VL_W = 8;
   localparam int VS_W = 7;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic            req_ready;
   logic            req_imm_form = 1'b1;
   logic [7:0]      req_zimm = '0;
   logic [XLEN-1:0] req_rs2_val = '0;
   logic [4:0]      req_rs1_idx = '0;
   logic [XLEN-1:0] req_rs1_val = '0;
   logic [4:0]      req_rd_idx = '0;
   logic            vstart_wr_en = 1'b0;
   logic [VS_W-1:0] vstart_wr_data = '0;
   logic            wb_en;
   logic [4:0]      wb_idx;
   logic [XLEN-1:0] wb_data;
   logic            vtype_vill, vtype_ma, vtype_ta;
   logic [2:0]      vtype_sew, vtype_lmul;
   logic [VL_W-1:0] vl_out;
   logic [VS_W-1:0] vstart_out;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   vcfg_unit #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(64), .MID_HALF(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_imm_form(req_imm_form), .req_zimm(req_zimm), .req_rs2_val(req_rs2_val),
      .req_rs1_idx(req_rs1_idx), .req_rs1_val(req_rs1_val), .req_rd_idx(req_rd_idx),
      .vstart_wr_en(vstart_wr_en), .vstart_wr_data(vstart_wr_data),
      .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
      .vtype_vill(vtype_vill), .vtype_ma(vtype_ma), .vtype_ta(vtype_ta),
      .vtype_sew(vtype_sew), .vtype_lmul(vtype_lmul),
      .vl_out(vl_out), .vstart_out(vstart_out)
   );

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_type(input string req, input bit vill, input bit ma,
                             input bit ta, input int sew, input int lmul);
      check(req, "vill", vtype_vill, vill);
      check(req, "ma", vtype_ma, ma);
      check(req, "ta", vtype_ta, ta);
      check(req, "sew", vtype_sew, sew);
      check(req, "lmul", vtype_lmul, lmul);
   endtask

   // one request: check write-back in the request cycle, length after the edge
   task automatic do_req(input string req, input bit imm, input logic [7:0] zimm,
                         input logic [XLEN-1:0] rs2v, input int rs1, input logic [XLEN-1:0] avl,
                         input int rd, input int exp_vl);
      @(negedge clk);
      req_valid    = 1'b1;
      req_imm_form = imm;
      req_zimm     = zimm;
      req_rs2_val  = rs2v;
      req_rs1_idx  = 5'(rs1);
      req_rs1_val  = avl;
      req_rd_idx   = 5'(rd);
      #1;
      check(req, "wb_data", wb_data, exp_vl);
      check("R2", "wb_en", wb_en, rd != 0);
      check("R2", "wb_idx", wb_idx, rd);
      check("R2", "req_ready", req_ready, 1);
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      check(req, "vl_out", vl_out, exp_vl);
      check("R11", "vstart", vstart_out, 0);
   endtask

   task automatic t_reset();
      check_type("R1", 1, 0, 0, 0, 0);
      check("R1", "vl", vl_out, 0);
      check("R1", "vstart", vstart_out, 0);
   endtask

   task automatic t_bands();
      // SEW 32, LMUL 1: VLMAX = 4
      do_req("R5", 1, 8'h10, '0, 5, 3, 1, 3);
      check_type("R3", 0, 0, 0, 2, 0);
      do_req("R5", 1, 8'h10, '0, 5, 4, 1, 4);
      do_req("R6", 1, 8'h10, '0, 5, 5, 1, 3);
      do_req("R6", 1, 8'h10, '0, 5, 7, 1, 4);
      do_req("R7", 1, 8'h10, '0, 5, 8, 1, 4);
      do_req("R7", 1, 8'h10, '0, 5, 32'h8000_0000, 1, 4);
   endtask

   task automatic t_regform();
      // register form, SEW 8, LMUL 8, ma set: VLMAX = 128
      do_req("R7", 0, 8'h00, 32'h0000_0083, 6, 1000, 7, 128);
      check_type("R3", 0, 1, 0, 0, 3);
      do_req("R6", 0, 8'h00, 32'h0000_0043, 6, 200, 7, 100);
      check_type("R3", 0, 0, 1, 0, 3);
      do_req("R5", 0, 8'h00, 32'h0000_0083, 6, 128, 7, 128);
   endtask

   task automatic t_frac();
      // SEW 8, LMUL 1/8: VLMAX = 2
      do_req("R6", 1, 8'h05, '0, 2, 3, 4, 2);
      check_type("R3", 0, 0, 0, 0, 5);
      do_req("R5", 1, 8'h05, '0, 2, 1, 4, 1);
      // SEW 64, LMUL 1 is legal: VLMAX = 2
      do_req("R5", 1, 8'h18, '0, 2, 2, 4, 2);
      check("R4", "vill legal", vtype_vill, 0);
   endtask

   task automatic t_illegal();
      logic [XLEN-1:0] bad_words [5] = '{32'h0000_0004, 32'h8000_0010, 32'h0000_0020,
                                          32'h0000_001F, 32'h0000_0100};
      foreach (bad_words[i]) begin
         do_req("R4", 0, 8'h00, bad_words[i], 1, 3, 2, 0);
         check_type("R4", 1, 0, 0, 0, 0);
      end
   endtask

   task automatic t_keep();
      // rs1 zero, rd nonzero: SEW 16, LMUL 2 -> VLMAX 16
      do_req("R8", 1, 8'h09, '0, 0, 5, 3, 16);
      // both zero, same ratio (SEW 32, LMUL 4): length kept
      do_req("R9", 1, 8'h12, '0, 0, 5, 0, 16);
      check_type("R9", 0, 0, 0, 2, 2);
      // both zero, ratio changes (SEW 32, LMUL 1): vill
      do_req("R9", 1, 8'h10, '0, 0, 5, 0, 0);
      check_type("R9", 1, 0, 0, 0, 0);
   endtask

   task automatic t_rd_zero();
      do_req("R10", 1, 8'h10, '0, 4, 2, 0, 2);
      check_type("R10", 0, 0, 0, 2, 0);
   endtask

   task automatic t_idle();
      @(negedge clk);
      req_valid    = 1'b0;
      req_imm_form = 1'b0;
      req_rs2_val  = 32'h0000_0004;
      req_rs1_idx  = 5'd9;
      req_rs1_val  = 32'd77;
      req_rd_idx   = 5'd9;
      #1;
      check("R2", "wb_en idle", wb_en, 0);
      repeat (3) @(posedge clk);
      #1;
      check("R12", "vl idle", vl_out, 2);
      check_type("R12", 0, 0, 0, 2, 0);
   endtask

   task automatic t_vstart();
      @(negedge clk);
      vstart_wr_en   = 1'b1;
      vstart_wr_data = 7'd7;
      @(posedge clk);
      #1;
      vstart_wr_en = 1'b0;
      check("R11", "vstart load", vstart_out, 7);
      @(negedge clk);
      vstart_wr_en   = 1'b1;
      vstart_wr_data = 7'd9;
      req_valid      = 1'b1;
      req_imm_form   = 1'b1;
      req_zimm       = 8'h10;
      req_rs1_idx    = 5'd1;
      req_rs1_val    = 32'd1;
      req_rd_idx     = 5'd1;
      @(posedge clk);
      #1;
      req_valid    = 1'b0;
      vstart_wr_en = 1'b0;
      check("R11", "vstart clear wins", vstart_out, 0);
      check("R5", "vl", vl_out, 1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_bands();
      t_regform();
      t_frac();
      t_illegal();
      t_keep();
      t_rd_zero();
      t_idle();
      t_vstart();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog all-R actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule